// File: doc/BRIEF.md
# Asynchronous SRAM Write Controller

A clocked state machine that turns a valid/ready request (address, 16-bit data, two byte enables) into a single write on an asynchronous 16-bit SRAM that has separate lower and upper byte selects. It drives the active-low first chip select, write enable and byte selects, the active-high second chip select, the address, and the data bus together with its tri-state enable.

Every interval is a whole number of clock cycles. Each interval is worked out when the design is built, from the clock period and a speed-grade parameter. The write always ends when write enable rises. The address, the data and the chip selects then stay in place for one more cycle. After that the pins return to idle, and no new request is taken until the minimum write cycle time has passed.

Top module: `sram_wr_ctrl`

## Requirements
- R1: `sram_we_no` is low only while `sram_cs1_no` is low, `sram_cs2_o` is high and at least one of `sram_lb_no`/`sram_ub_no` is low.
- R2: Byte enable bit 0 selects the lower byte (data bits 7:0, `sram_lb_no` low). Bit 1 selects the upper byte (bits 15:8, `sram_ub_no` low). During the strobe each select is low exactly when its enable was set in the accepted request.
- R3: Write enable stays low for S cycles. S is the largest of ceil(A/P), ceil(W/P) and ceil(D/P). P is CLK_PERIOD_NS. Address-and-select-to-end A, pulse W and data setup D are, in ns, 35/35/20 for SPEED_GRADE 0, 45/40/25 for grade 1, and 60/50/30 for grade 2.
- R4: Address, data and `sram_dq_oe_o` are driven from the first strobe cycle. They hold the values captured at acceptance through the cycle after write enable rises, and the chip selects stay active in that cycle. Request inputs that change while the block is busy have no effect.
- R5: In the cycle after the hold cycle, `sram_cs1_no`, `sram_lb_no` and `sram_ub_no` are high, and `sram_cs2_o` and `sram_dq_oe_o` are low.
- R6: `req_ready_o` is low for max(ceil(C/P)−1, S+1) cycles after each acceptance. C, the write cycle time, is 45, 55 or 70 ns by grade. Requests held valid are therefore accepted every max(ceil(C/P), S+2) cycles.
- R7: During reset and after its release with no request, `req_ready_o` is high, `sram_we_no`, `sram_cs1_no`, `sram_lb_no` and `sram_ub_no` are high, and `sram_cs2_o` and `sram_dq_oe_o` are low.
- R8: A request with both byte enables clear leaves write enable and both byte selects high, yet keeps ready low for the same time as any other write.
- R9: With OE_TIED_LOW=1, S also covers ceil((Z+D+1)/P). Z, the output-to-high-Z time, is 20, 20 or 30 ns by grade, so the pulse strictly exceeds Z+D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Ready to accept a request |
| req_addr_i | input | ADDR_W | Word address |
| req_data_i | input | 16 | Write data |
| req_be_i | input | 2 | Byte enables (bit 0 lower, bit 1 upper) |
| sram_addr_o | output | ADDR_W | SRAM address |
| sram_dq_o | output | 16 | SRAM data out |
| sram_dq_oe_o | output | 1 | Tri-state enable for the data bus |
| sram_cs1_no | output | 1 | Chip select 1, active low |
| sram_cs2_o | output | 1 | Chip select 2, active high |
| sram_we_no | output | 1 | Write enable, active low |
| sram_lb_no | output | 1 | Lower byte select, active low |
| sram_ub_no | output | 1 | Upper byte select, active low |

## Verification
A wrong state or a miscounted timer shows up within one write: the write-enable pulse comes out longer or shorter than S, the chip selects drop in the hold cycle, or ready returns early or late. Lane or capture faults appear on the byte selects and on the data bus during the strobe of the same request. The bench changes the request inputs while the block is busy, so a design that does not hold its captured values shows the mismatch in the next cycle. Back-to-back requests reveal a wrong recovery count through the spacing between acceptances. The bench checks two speed configurations, and one of them has the output-enable rule enabled.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STROBE = 2'd1,
    ST_HOLD   = 2'd2,
    ST_WAIT   = 2'd3
  } wr_state_e;

  typedef enum int {
    T_CYCLE = 0,
    T_ADDR  = 1,
    T_PULSE = 2,
    T_SETUP = 3,
    T_HIZ   = 4
  } wr_time_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Minimum times in ns, grade 0 fastest
  function automatic int grade_ns(input int grade, input wr_time_e kind);
    int g;
    g = (grade < 0) ? 0 : ((grade > 2) ? 2 : grade);
    case (kind)
      T_CYCLE: return (g == 0) ? 45 : ((g == 1) ? 55 : 70);
      T_ADDR:  return (g == 0) ? 35 : ((g == 1) ? 45 : 60);
      T_PULSE: return (g == 0) ? 35 : ((g == 1) ? 40 : 50);
      T_SETUP: return (g == 0) ? 20 : ((g == 1) ? 25 : 30);
      default: return (g == 2) ? 30 : 20;
    endcase
  endfunction

  function automatic int strobe_cycles(input int grade, input int per, input bit oe_low);
    int s;
    s = max2(ceil_div(grade_ns(grade, T_ADDR), per), ceil_div(grade_ns(grade, T_PULSE), per));
    s = max2(s, ceil_div(grade_ns(grade, T_SETUP), per));
    if (oe_low)
      s = max2(s, ceil_div(grade_ns(grade, T_HIZ) + grade_ns(grade, T_SETUP) + 1, per));
    return max2(s, 1);
  endfunction

  // Strobe, hold and the idle cycle already count toward the cycle time
  function automatic int wait_cycles(input int grade, input int per, input bit oe_low);
    return max2(ceil_div(grade_ns(grade, T_CYCLE), per) - strobe_cycles(grade, per, oe_low) - 2, 0);
  endfunction

endpackage

// File: rtl/sram_wr_timer.sv
module sram_wr_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
  import sram_wr_pkg::*;
#(
  parameter int S_CYC = 4,
  parameter int W_CYC = 0,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             tmr_zero_i,
  output logic             ready_o,
  output logic             accept_o,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output wr_state_e        state_d_o
);

  localparam int BUSY_CYC = S_CYC + 1 + W_CYC;
  localparam int BW       = $clog2(BUSY_CYC + 2);

  wr_state_e state_q, state_d;

  assign ready_o  = (state_q == ST_IDLE);
  assign accept_o = ready_o && req_valid_i;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    case (state_q)
      ST_IDLE: if (req_valid_i) begin
        state_d    = ST_STROBE;
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(S_CYC - 1);
      end
      ST_STROBE: if (tmr_zero_i) state_d = ST_HOLD;
      ST_HOLD: begin
        if (W_CYC > 0) begin
          state_d    = ST_WAIT;
          tmr_load_o = 1'b1;
          tmr_val_o  = CNT_W'((W_CYC > 0) ? W_CYC - 1 : 0);
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: if (tmr_zero_i) state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_d_o = state_d;

  // busy-window counter for R6
  logic [BW-1:0] busy_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       busy_cnt_q <= '0;
    else if (!ready_o) busy_cnt_q <= busy_cnt_q + 1'b1;
    else               busy_cnt_q <= '0;
  end

  assert_busy_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (busy_cnt_q == BW'(BUSY_CYC)));

  assert_ready_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !ready_o);

endmodule

// File: rtl/sram_wr_datapath.sv
module sram_wr_datapath
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int S_CYC  = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     accept_i,
  input  wr_state_e                state_d_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [DATA_W-1:0]        req_data_i,
  input  logic [DATA_W/8-1:0]      req_be_i,
  output logic [ADDR_W-1:0]        sram_addr_o,
  output logic [DATA_W-1:0]        sram_dq_o,
  output logic                     sram_dq_oe_o,
  output logic                     sram_cs_o,
  output logic                     sram_we_o,
  output logic [DATA_W/8-1:0]      sram_lane_o
);

  localparam int LANES = DATA_W / 8;
  localparam int WW    = $clog2(S_CYC + 2);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [LANES-1:0]  be_q, be_sel, lane_q;
  logic              cs_q, we_q;
  logic              cs_d;

  assign be_sel = accept_i ? req_be_i : be_q;
  assign cs_d   = (state_d_i == ST_STROBE) || (state_d_i == ST_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      be_q   <= '0;
    end else if (accept_i) begin
      addr_q <= req_addr_i;
      data_q <= req_data_i;
      be_q   <= req_be_i;
    end
  end

  // Registered pin controls, glitch-free toward the SRAM
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q <= 1'b0;
      we_q <= 1'b0;
    end else begin
      cs_q <= cs_d;
      we_q <= (state_d_i == ST_STROBE) && (|be_sel);
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lane_q[i] <= 1'b0;
      else         lane_q[i] <= cs_d && be_sel[i];
    end
  end

  assign sram_addr_o  = addr_q;
  assign sram_dq_o    = data_q;
  assign sram_dq_oe_o = cs_q;
  assign sram_cs_o    = cs_q;
  assign sram_we_o    = we_q;
  assign sram_lane_o  = lane_q;

  logic [WW-1:0] we_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   we_cnt_q <= '0;
    else if (we_q) we_cnt_q <= we_cnt_q + 1'b1;
    else           we_cnt_q <= '0;
  end

  assert_we_gated_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> (cs_q && (|lane_q)));

  assert_pulse_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_q) |-> (we_cnt_q == WW'(S_CYC)));

  assert_hold_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_q) |-> (cs_q && sram_dq_oe_o && $stable(sram_dq_o) && $stable(sram_addr_o)));

  assert_strobe_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q && $past(we_q)) |-> ($stable(sram_dq_o) && $stable(sram_addr_o) && $stable(lane_q)));

endmodule

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int CLK_PERIOD_NS = 10,
  parameter int SPEED_GRADE   = 0,
  parameter bit OE_TIED_LOW   = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [15:0]       req_data_i,
  input  logic [1:0]        req_be_i,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [15:0]       sram_dq_o,
  output logic              sram_dq_oe_o,
  output logic              sram_cs1_no,
  output logic              sram_cs2_o,
  output logic              sram_we_no,
  output logic              sram_lb_no,
  output logic              sram_ub_no
);

  localparam int S_CYC = strobe_cycles(SPEED_GRADE, CLK_PERIOD_NS, OE_TIED_LOW);
  localparam int W_CYC = wait_cycles(SPEED_GRADE, CLK_PERIOD_NS, OE_TIED_LOW);
  localparam int CNT_W = max2($clog2(max2(S_CYC, W_CYC) + 1), 1);

  logic             tmr_zero, tmr_load, accept, cs, we;
  logic [CNT_W-1:0] tmr_val;
  logic [1:0]       lane;
  wr_state_e        state_d;

  sram_wr_fsm #(.S_CYC(S_CYC), .W_CYC(W_CYC), .CNT_W(CNT_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .tmr_zero_i  (tmr_zero),
    .ready_o     (req_ready_o),
    .accept_o    (accept),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .state_d_o   (state_d)
  );

  sram_wr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  sram_wr_datapath #(.ADDR_W(ADDR_W), .DATA_W(16), .S_CYC(S_CYC)) u_dp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (accept),
    .state_d_i    (state_d),
    .req_addr_i   (req_addr_i),
    .req_data_i   (req_data_i),
    .req_be_i     (req_be_i),
    .sram_addr_o  (sram_addr_o),
    .sram_dq_o    (sram_dq_o),
    .sram_dq_oe_o (sram_dq_oe_o),
    .sram_cs_o    (cs),
    .sram_we_o    (we),
    .sram_lane_o  (lane)
  );

  assign sram_cs1_no = ~cs;
  assign sram_cs2_o  = cs;
  assign sram_we_no  = ~we;
  assign sram_lb_no  = ~lane[0];
  assign sram_ub_no  = ~lane[1];

endmodule

// File: tb/tb_sram_wr_ctrl.sv
module tb_sram_wr_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic [1:0] req_be = '0;

  logic rdy [2];
  logic [AW-1:0] s_addr [2];
  logic [15:0] s_dq [2];
  logic s_oe [2], s_cs1_n [2], s_cs2 [2], s_we_n [2], s_lb_n [2], s_ub_n [2];

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_wr_ctrl #(.ADDR_W(AW), .CLK_PERIOD_NS(CLK_PERIOD), .SPEED_GRADE(0), .OE_TIED_LOW(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(rdy[0]),
    .req_addr_i(req_addr), .req_data_i(req_data), .req_be_i(req_be),
    .sram_addr_o(s_addr[0]), .sram_dq_o(s_dq[0]), .sram_dq_oe_o(s_oe[0]),
    .sram_cs1_no(s_cs1_n[0]), .sram_cs2_o(s_cs2[0]), .sram_we_no(s_we_n[0]),
    .sram_lb_no(s_lb_n[0]), .sram_ub_no(s_ub_n[0]));

  sram_wr_ctrl #(.ADDR_W(AW), .CLK_PERIOD_NS(CLK_PERIOD), .SPEED_GRADE(2), .OE_TIED_LOW(1'b1)) dut_oe (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(rdy[1]),
    .req_addr_i(req_addr), .req_data_i(req_data), .req_be_i(req_be),
    .sram_addr_o(s_addr[1]), .sram_dq_o(s_dq[1]), .sram_dq_oe_o(s_oe[1]),
    .sram_cs1_no(s_cs1_n[1]), .sram_cs2_o(s_cs2[1]), .sram_we_no(s_we_n[1]),
    .sram_lb_no(s_lb_n[1]), .sram_ub_no(s_ub_n[1]));

  // Expected timing straight from the requirement tables
  function automatic int tns(input int g, input int k);
    int t [3][5] = '{'{45, 35, 35, 20, 20}, '{55, 45, 40, 25, 20}, '{70, 60, 50, 30, 30}};
    return t[g][k];
  endfunction
  function automatic int cdiv(input int n);
    return (n + CLK_PERIOD - 1) / CLK_PERIOD;
  endfunction
  function automatic int mx(input int a, input int b);
    return a > b ? a : b;
  endfunction
  function automatic int exp_s(input int g, input bit oe);
    int s;
    s = mx(mx(cdiv(tns(g, 1)), cdiv(tns(g, 2))), cdiv(tns(g, 3)));
    if (oe) s = mx(s, cdiv(tns(g, 4) + tns(g, 3) + 1));
    return s;
  endfunction

  int s_exp [2];
  int busy_exp [2];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int we_low [2], busy [2];
  bit seen_rdy [2], e_strobe [2], e_hold [2], e_idle [2];

  task automatic sample(input int i, input int cyc, input logic [AW-1:0] a,
                        input logic [15:0] d, input logic [1:0] be);
    if (!seen_rdy[i]) begin
      if (rdy[i]) seen_rdy[i] = 1'b1;
      else busy[i]++;
    end
    if (!s_we_n[i]) begin
      we_low[i]++;
      if (s_cs1_n[i] || !s_cs2[i] || (s_lb_n[i] && s_ub_n[i])) e_strobe[i] = 1'b1;
    end
    if (cyc <= s_exp[i]) begin
      if (s_we_n[i] != (be == 2'b00) || s_cs1_n[i] || !s_cs2[i] || !s_oe[i] ||
          s_lb_n[i] != !be[0] || s_ub_n[i] != !be[1] || s_addr[i] != a || s_dq[i] != d)
        e_strobe[i] = 1'b1;
    end else if (cyc == s_exp[i] + 1) begin
      if (!s_we_n[i] || s_cs1_n[i] || !s_cs2[i] || !s_oe[i] || s_addr[i] != a || s_dq[i] != d)
        e_hold[i] = 1'b1;
    end else if (cyc == s_exp[i] + 2) begin
      if (!s_cs1_n[i] || s_cs2[i] || !s_lb_n[i] || !s_ub_n[i] || s_oe[i] || !s_we_n[i])
        e_idle[i] = 1'b1;
    end
  endtask

  task automatic run_write(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    while (!(rdy[0] && rdy[1])) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_data = ~d; req_be = ~be;
    for (int i = 0; i < 2; i++) begin
      we_low[i] = 0; busy[i] = 0; seen_rdy[i] = 1'b0;
      e_strobe[i] = 1'b0; e_hold[i] = 1'b0; e_idle[i] = 1'b0;
    end
    for (int cyc = 1; cyc <= 12; cyc++) begin
      sample(0, cyc, a, d, be);
      sample(1, cyc, a, d, be);
      @(negedge clk);
    end
    for (int i = 0; i < 2; i++) begin
      if (be == 2'b00) chk(we_low[i] == 0, "R8 no-byte write", we_low[i], 0);
      else if (i == 1) chk(we_low[i] == s_exp[i], "R9 pulse with OE low", we_low[i], s_exp[i]);
      else chk(we_low[i] == s_exp[i], "R3 pulse length", we_low[i], s_exp[i]);
      chk(!e_strobe[i], "R1/R2 strobe pins and lanes", e_strobe[i], 0);
      chk(!e_hold[i], "R4 hold cycle", e_hold[i], 0);
      chk(!e_idle[i], "R5 release", e_idle[i], 0);
      chk(busy[i] == busy_exp[i], be == 2'b00 ? "R8 busy time" : "R6 busy time", busy[i], busy_exp[i]);
    end
  endtask

  task automatic test_reset();
    #(CLK_PERIOD * 2 + 1);
    for (int i = 0; i < 2; i++)
      chk(rdy[i] && s_we_n[i] && s_cs1_n[i] && !s_cs2[i] && s_lb_n[i] && s_ub_n[i] && !s_oe[i],
          "R7 in reset", 0, 1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    for (int i = 0; i < 2; i++)
      chk(rdy[i] && s_we_n[i] && s_cs1_n[i] && !s_cs2[i] && !s_oe[i], "R7 after reset", 0, 1);
  endtask

  task automatic test_back_to_back();
    int t, first [2], second [2];
    @(negedge clk);
    while (!(rdy[0] && rdy[1])) @(negedge clk);
    first = '{-1, -1}; second = '{-1, -1};
    req_valid = 1'b1; req_addr = 19'h00abc; req_data = 16'h1234; req_be = 2'b11;
    for (t = 0; t < 30; t++) begin
      for (int i = 0; i < 2; i++)
        if (rdy[i]) begin
          if (first[i] < 0) first[i] = t;
          else if (second[i] < 0) second[i] = t;
        end
      @(negedge clk);
    end
    req_valid = 1'b0;
    for (int i = 0; i < 2; i++)
      chk(second[i] - first[i] == busy_exp[i] + 1, "R6 accept spacing", second[i] - first[i], busy_exp[i] + 1);
  endtask

  initial begin
    s_exp[0] = exp_s(0, 1'b0);
    s_exp[1] = exp_s(2, 1'b1);
    busy_exp[0] = mx(cdiv(tns(0, 0)) - 1, s_exp[0] + 1);
    busy_exp[1] = mx(cdiv(tns(2, 0)) - 1, s_exp[1] + 1);
    test_reset();
    run_write(19'h12345, 16'hbeef, 2'b11);
    run_write(19'h00001, 16'h00a5, 2'b01);
    run_write(19'h7ffff, 16'h5a00, 2'b10);
    run_write(19'h2a2a2, 16'hffff, 2'b00);
    test_back_to_back();
    run_write(19'h00000, 16'h0000, 2'b11);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule